// File: doc/BRIEF.md
# Four-Channel Memory-to-Memory DMA Engine

This block copies blocks of data from one memory location to another on behalf of four independent channels. Software programs each channel through a flat 32-bit register bus: an element count, a 64-bit source address, a 64-bit destination address and a control word. The write of the control word that sets the enable bit also launches the transfer. The engine then moves the data one element at a time over a single request/acknowledge memory master port. An element is 1, 2, 4 or 8 bytes wide. Each element is a read from the source address followed by a write of the same data to the destination address.

For each channel, the source address and the destination address can each either step by the element width after every element or stay fixed. A fixed address suits a data port that is read or written many times. When several channels are pending, they take turns on the memory port in round-robin order, with one element per turn. A completion flag for each channel is kept in a shared status word that is cleared by writing ones. A busy output marks activity. The scatter-gather pointer registers only store values; nothing in the engine uses them.

Top module: `dma_quad_engine`

## Requirements
- R1: Channel n (0..3) owns register offsets 8n+0..8n+7: 0 control, 1 count, 2 source high, 3 source low, 4 destination high, 5 destination low, 6 scatter-gather high, 7 scatter-gather low. Each register reads back the value last written to it, except where R6 and R8 say otherwise.
- R2: Each 64-bit address is formed from a high (bits 63:32) and a low (bits 31:0) register. A write to one half leaves the other half unchanged.
- R3: A transfer starts only when the control register is written with bit 31 set while the count register's bits 15:0 are nonzero. A channel started with a count of zero produces no memory request and does not raise busy.
- R4: Control bits 26:25 select an element of 1 << field bytes. During every request of an element, `mem_size` carries this field.
- R5: Each element is a read at the source address (`mem_we`=0) and then a write at the destination address (`mem_we`=1). The written data equals the read data in its low 8·(1<<field) bits, with the upper bits zero. Byte order is little-endian: the byte at address A+i travels in bits 8i+7:8i.
- R6: After each element, the source address advances by the element width when control bit 23 is set, and the destination address does the same when control bit 24 is set. A clear bit keeps that address fixed. The address registers read back the advanced values.
- R7: Only one channel uses the memory port at a time. The channel that follows the last-served one in ascending circular order is granted next, for exactly one element. After reset, channel 0 is first in the order.
- R8: The status register sits at offset 0x20. When channel n finishes its last element, status bit 31−n is set. Writing the status register clears every bit that is 1 in the written value. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R9: `busy` is high exactly while at least one channel has elements left. `mem_req` is never high while `busy` is low.
- R10: Offsets 0x21 and above read as zero, and writes to them change no register.
- R11: Reset clears every channel register, the status register and busy, and leaves `mem_req` low.
- R12: Once `mem_req` is raised, it stays high with the address, direction and size unchanged until a cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register offset, used for both reads and writes |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the element |
| mem_size | output | 2 | Element width code (bytes = 1 << code) |
| mem_wdata | output | 64 | Write data, little-endian, in the low lanes |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` on a read |
| busy | output | 1 | At least one channel is active |

## Verification
A corrupted address register or a wrong arbitration pointer shows up on the very next memory request of the affected element, as an address that does not match the bench model's expectation for the channel that should own the turn. A wrong remaining-element count is seen later: the done flag or the busy output changes one element too early or too late, or an extra request appears after a channel should have finished. A wrong data lane or a missing mask appears on the write phase of the same element.

// File: rtl/dma_quad_engine.sv
module dma_quad_engine #(
  parameter int NCH = 4,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] reg_addr,
  input  logic           reg_we,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [63:0]    mem_addr,
  output logic [1:0]     mem_size,
  output logic [63:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [63:0]    mem_rdata,
  output logic           busy
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [RAW-1:0] ST_ADDR = RAW'(8 * NCH);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  logic [31:0]    ctrl [NCH];
  logic [31:0]    cnt  [NCH];
  logic [63:0]    src  [NCH];
  logic [63:0]    dst  [NCH];
  logic [63:0]    sgp  [NCH];
  logic [15:0]    rem  [NCH];
  logic [NCH-1:0] act;
  logic [31:0]    stat;
  st_t            st;
  logic [CW-1:0]  cur, last, pick;
  logic [63:0]    hold;

  wire            in_ch = reg_addr < ST_ADDR;
  wire [CW-1:0]   sel   = reg_addr[3 +: CW];
  wire [2:0]      fld   = reg_addr[2:0];
  wire [1:0]      csz   = ctrl[cur][26:25];
  wire [63:0]     stp   = 64'd1 << csz;
  wire            fin   = (st == S_WR) && mem_ack && (rem[cur] == 16'd1);
  wire [31:0]     set_v = fin ? (32'h8000_0000 >> cur) : 32'd0;
  wire [31:0]     clr_v = (reg_we && reg_addr == ST_ADDR) ? reg_wdata : 32'd0;

  function automatic logic [63:0] lane_mask(input logic [1:0] s);
    case (s)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  always_comb begin
    logic found;
    int   j;
    pick  = last;
    found = 1'b0;
    for (int i = 1; i <= NCH; i++) begin
      j = (int'(last) + i) % NCH;
      if (!found && act[j]) begin
        pick  = CW'(j);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = 32'd0;
    if (in_ch) begin
      case (fld)
        3'd0: reg_rdata = ctrl[sel];
        3'd1: reg_rdata = cnt[sel];
        3'd2: reg_rdata = src[sel][63:32];
        3'd3: reg_rdata = src[sel][31:0];
        3'd4: reg_rdata = dst[sel][63:32];
        3'd5: reg_rdata = dst[sel][31:0];
        3'd6: reg_rdata = sgp[sel][63:32];
        default: reg_rdata = sgp[sel][31:0];
      endcase
    end else if (reg_addr == ST_ADDR) begin
      reg_rdata = stat;
    end
  end

  assign mem_req   = st != S_IDLE;
  assign mem_we    = st == S_WR;
  assign mem_addr  = (st == S_WR) ? dst[cur] : src[cur];
  assign mem_size  = csz;
  assign mem_wdata = hold;
  assign busy      = |act;

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= 32'd0;
    else        stat <= (stat & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) begin
        ctrl[n] <= '0;
        cnt[n]  <= '0;
        src[n]  <= '0;
        dst[n]  <= '0;
        sgp[n]  <= '0;
        rem[n]  <= '0;
      end
      act  <= '0;
      st   <= S_IDLE;
      cur  <= '0;
      last <= CW'(NCH - 1);
      hold <= '0;
    end else begin
      case (st)
        S_IDLE: if (|act) begin
          cur  <= pick;
          last <= pick;
          st   <= S_RD;
        end
        S_RD: if (mem_ack) begin
          hold <= mem_rdata & lane_mask(csz);
          st   <= S_WR;
        end
        default: if (mem_ack) begin
          if (ctrl[cur][23]) src[cur] <= src[cur] + stp;
          if (ctrl[cur][24]) dst[cur] <= dst[cur] + stp;
          rem[cur] <= rem[cur] - 16'd1;
          if (rem[cur] == 16'd1) act[cur] <= 1'b0;
          st <= S_IDLE;
        end
      endcase
      if (reg_we && in_ch) begin
        case (fld)
          3'd0: begin
            ctrl[sel] <= reg_wdata;
            if (reg_wdata[31] && cnt[sel][15:0] != 16'd0) begin
              act[sel] <= 1'b1;
              rem[sel] <= cnt[sel][15:0];
            end
          end
          3'd1: cnt[sel]        <= reg_wdata;
          3'd2: src[sel][63:32] <= reg_wdata;
          3'd3: src[sel][31:0]  <= reg_wdata;
          3'd4: dst[sel][63:32] <= reg_wdata;
          3'd5: dst[sel][31:0]  <= reg_wdata;
          3'd6: sgp[sel][63:32] <= reg_wdata;
          default: sgp[sel][31:0] <= reg_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_quad_engine_chk.sv
module dma_quad_engine_chk #(
  parameter int NCH = 4,
  parameter int RAW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           mem_req,
  input logic           mem_ack,
  input logic           mem_we,
  input logic [63:0]    mem_addr,
  input logic [1:0]     mem_size,
  input logic [63:0]    mem_wdata,
  input logic [RAW-1:0] reg_addr,
  input logic [31:0]    reg_rdata,
  input logic [NCH-1:0] act,
  input logic [31:0]    stat
);
  localparam logic [RAW-1:0] ST_ADDR = RAW'(8 * NCH);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr > ST_ADDR |-> reg_rdata == 32'd0);

  assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_size == 2'd0 |-> mem_wdata[63:8] == 56'd0);

  for (genvar n = 0; n < NCH; n++) begin : g_done
    assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act[n]) |-> stat[31-n]);
  end
endmodule

bind dma_quad_engine dma_quad_engine_chk #(.NCH(NCH), .RAW(RAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .act(act), .stat(stat)
);

// File: tb/dma_quad_engine_tb_top.sv
module dma_quad_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, busy;
  logic [63:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #10 clk = ~clk;

  dma_quad_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy)
  );

  int nchk = 0, nfail = 0;
  int lat = 0, wcnt = 0;

  logic [31:0] mctrl [4], mcnt [4];
  logic [63:0] msrc [4], mdst [4], msg [4];
  int          mrem [4];
  bit          mact [4];
  logic [31:0] mstat = '0;
  int          mlast = 3, mcur = 0;
  logic [63:0] mdata;
  logic [7:0]  mem [logic [63:0]];

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic [7:0] ini(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rdb(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : ini(a);
  endfunction

  function automatic logic [31:0] mreg(input int off);
    int c, k;
    if (off >= 32) return (off == 32) ? mstat : 32'd0;
    c = off / 8; k = off % 8;
    case (k)
      0: return mctrl[c];
      1: return mcnt[c];
      2: return msrc[c][63:32];
      3: return msrc[c][31:0];
      4: return mdst[c][63:32];
      5: return mdst[c][31:0];
      6: return msg[c][63:32];
      default: return msg[c][31:0];
    endcase
  endfunction

  task automatic wr(input int off, input logic [31:0] d);
    int c, k;
    @(negedge clk);
    reg_addr = 8'(off); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (off < 32) begin
      c = off / 8; k = off % 8;
      case (k)
        0: begin
          mctrl[c] = d;
          if (d[31] && mcnt[c][15:0] != 16'd0) begin mact[c] = 1'b1; mrem[c] = int'(mcnt[c][15:0]); end
        end
        1: mcnt[c] = d;
        2: msrc[c][63:32] = d;
        3: msrc[c][31:0] = d;
        4: mdst[c][63:32] = d;
        5: mdst[c][31:0] = d;
        6: msg[c][63:32] = d;
        default: msg[c][31:0] = d;
      endcase
    end else if (off == 32) begin
      mstat = mstat & ~d;
    end
  endtask

  task automatic rd(input int off, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 8'(off);
    #1 v = reg_rdata;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] v;
    for (int off = 0; off < 40; off++) begin
      rd(off, v);
      chk(v === mreg(off), req, 64'(v), 64'(mreg(off)));
    end
  endtask

  task automatic service();
    int m, w;
    logic [63:0] v, msk;
    bit any;
    if (!mem_we) begin
      any = 1'b0; m = mlast;
      for (int i = 1; i <= 4; i++) if (!any && mact[(mlast + i) % 4]) begin m = (mlast + i) % 4; any = 1'b1; end
      if (!any) begin
        chk(1'b0, "R3 request with no active channel", mem_addr, 64'd0);
        mem_rdata = '0;
        return;
      end
      mcur = m; mlast = m;
      w = int'(mctrl[m][26:25]);
      chk(mem_addr === msrc[m], "R7 read address of granted channel", mem_addr, msrc[m]);
      chk(mem_size === mctrl[m][26:25], "R4 element size code", 64'(mem_size), 64'(mctrl[m][26:25]));
      msk = '0;
      for (int i = 0; i < 8; i++) begin
        v[8*i +: 8] = rdb(mem_addr + 64'(i));
        if (i < (1 << w)) msk[8*i +: 8] = 8'hFF;
      end
      mem_rdata = v;
      mdata = v & msk;
    end else begin
      w = int'(mctrl[mcur][26:25]);
      chk(mem_addr === mdst[mcur], "R6 write address", mem_addr, mdst[mcur]);
      chk(mem_wdata === mdata, "R5 write data", mem_wdata, mdata);
      for (int i = 0; i < (1 << w); i++) mem[mem_addr + 64'(i)] = mem_wdata[8*i +: 8];
      if (mctrl[mcur][23]) msrc[mcur] = msrc[mcur] + 64'(1 << w);
      if (mctrl[mcur][24]) mdst[mcur] = mdst[mcur] + 64'(1 << w);
      mrem[mcur]--;
      if (mrem[mcur] == 0) begin
        mact[mcur] = 1'b0;
        mstat = mstat | (32'h8000_0000 >> mcur);
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0;
          service();
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic wait_idle(input string req);
    int t = 0;
    while (busy !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && !mact[0] && !mact[1] && !mact[2] && !mact[3], req, 64'(busy), 64'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      mctrl[c] = '0; mcnt[c] = '0; msrc[c] = '0; mdst[c] = '0; msg[c] = '0; mrem[c] = 0; mact[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    chk(busy === 1'b0, "R11 busy after reset", 64'(busy), 64'd0);
    chk(mem_req === 1'b0, "R11 mem_req after reset", 64'(mem_req), 64'd0);
    check_regs("R11 register reset value");

    // R1 / R2: register map and independent halves
    for (int k = 1; k < 8; k++) wr(8 + k, 32'h1100_0000 + 32'(k * 32'h0101));
    check_regs("R1 register readback");
    wr(8 + 3, 32'hCAFE_0001);
    wr(8 + 6, 32'h7777_0000);
    check_regs("R2 half write keeps other half");

    // R10: unmapped offsets
    wr(33, 32'hFFFF_FFFF);
    wr(63, 32'h1234_5678);
    wr(255, 32'hDEAD_BEEF);
    rd(33, v); chk(v === 32'd0, "R10 offset 0x21 reads zero", 64'(v), 64'd0);
    rd(255, v); chk(v === 32'd0, "R10 offset 0xFF reads zero", 64'(v), 64'd0);
    check_regs("R10 no register changed");

    // R3: zero low count starts nothing
    wr(16 + 1, 32'h0001_0000);
    wr(16 + 3, 32'h0000_3000);
    wr(16 + 5, 32'h0000_4000);
    wr(16 + 0, 32'h8180_0000);
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R3 zero count keeps busy low", 64'(busy), 64'd0);
    rd(32, v); chk(v === 32'd0, "R3 zero count sets no done flag", 64'(v), 64'd0);

    // R5 / R6 / R8: channel 0, 4-byte elements, both addresses step
    lat = 0;
    wr(1, 32'd5); wr(3, 32'h0000_1000); wr(5, 32'h0000_8000);
    wr(0, 32'h8580_0000);
    wait_idle("R9 busy falls after channel 0");
    for (int i = 0; i < 20; i++)
      chk(rdb(64'h8000 + 64'(i)) === ini(64'h1000 + 64'(i)), "R5 copied byte ch0", 64'(rdb(64'h8000 + 64'(i))), 64'(ini(64'h1000 + 64'(i))));
    rd(3, v); chk(v === 32'h0000_1014, "R6 source advanced by 20", 64'(v), 64'h1014);
    rd(32, v); chk(v === 32'h8000_0000, "R8 done bit of channel 0", 64'(v), 64'h8000_0000);

    // R6: channel 3, 8-byte elements, fixed source, stepping destination, high halves set
    lat = 2;
    wr(24 + 1, 32'd3); wr(24 + 2, 32'h0000_0001); wr(24 + 3, 32'h0000_2000);
    wr(24 + 4, 32'h0000_0002); wr(24 + 5, 32'h0000_0100);
    wr(24 + 0, 32'h8700_0000);
    wait_idle("R9 busy falls after channel 3");
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 8; i++)
        chk(rdb(64'h2_0000_0100 + 64'(8*j + i)) === ini(64'h1_0000_2000 + 64'(i)), "R6 fixed source repeats", 64'(rdb(64'h2_0000_0100 + 64'(8*j + i))), 64'(ini(64'h1_0000_2000 + 64'(i))));
    check_regs("R6 address registers after channel 3");

    // R6: channel 1, bytes, stepping source, fixed destination
    wr(8 + 1, 32'd4); wr(8 + 2, 32'd0); wr(8 + 3, 32'h0000_5000); wr(8 + 4, 32'd0); wr(8 + 5, 32'h0000_6000);
    wr(8 + 0, 32'h8080_0000);
    wait_idle("R9 busy falls after channel 1");
    chk(rdb(64'h6000) === ini(64'h5003), "R6 fixed destination holds last byte", 64'(rdb(64'h6000)), 64'(ini(64'h5003)));
    chk(rdb(64'h6001) === ini(64'h6001), "R5 neighbour byte untouched", 64'(rdb(64'h6001)), 64'(ini(64'h6001)));
    check_regs("R6 address registers after channel 1");

    // R7: all four channels contend
    wr(32, 32'hFFFF_FFFF);
    lat = 3;
    for (int c = 0; c < 4; c++) begin
      wr(8*c + 1, 32'd2);
      wr(8*c + 2, 32'd0); wr(8*c + 3, 32'h0001_0000 + 32'(c * 32'h100));
      wr(8*c + 4, 32'd0); wr(8*c + 5, 32'h0002_0000 + 32'(c * 32'h100));
    end
    for (int c = 0; c < 4; c++) wr(8*c, 32'h8180_0000 | (32'(c) << 25));
    wait_idle("R7 all channels finish");
    rd(32, v); chk(v === 32'hF000_0000, "R8 all done bits", 64'(v), 64'hF000_0000);
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 2 * (1 << c); i++)
        chk(rdb(64'h2_0000 + 64'(c * 256 + i)) === ini(64'h1_0000 + 64'(c * 256 + i)), "R7 contended copy", 64'(rdb(64'h2_0000 + 64'(c * 256 + i))), 64'(ini(64'h1_0000 + 64'(c * 256 + i))));

    // R8: write-one-to-clear
    wr(32, 32'h4000_0000);
    rd(32, v); chk(v === 32'hB000_0000, "R8 clear one bit", 64'(v), 64'hB000_0000);
    wr(32, 32'h0FFF_FFFF);
    rd(32, v); chk(v === 32'hB000_0000, "R8 zero bits keep flags", 64'(v), 64'hB000_0000);
    wr(32, 32'hFFFF_FFFF);
    rd(32, v); chk(v === 32'd0, "R8 clear all", 64'(v), 64'd0);
    check_regs("R1 final register file");

    finish_run();
  end
endmodule